// File: doc/BRIEF.md
# Glitch-Free Power-Down Clock Sequencer

This block sits between free-running clock sources and the clock pins of a system clock generator. It takes an asynchronous, active-low power-down request and stops a set of clock outputs in a fixed order. Each output is stopped only at a point in its own waveform where stopping cannot cut a pulse short. Once every output has been parked and has confirmed it, the block raises a power-down command for the PLL and VCO. Releasing the request drops that command at once. The clocks then restart only after the PLL reports lock for a programmable number of cycles.

The request is brought into the domain of the CPU complement clock, which is the sequencing clock. The PCI free-running output stops first. The buffered 66 MHz output follows, and after it come PCI, USB/DOT, REF and the true CPU output. The low-parked outputs stop on a falling edge. The true CPU output is parked high, and the enable of the complement CPU pin is withdrawn at the same time. Each domain has its own stop flop, its own request synchronizer and an acknowledgment that returns to the sequencer. A slow domain such as REF therefore only lengthens the wait before PLL power-down.

Top module: `pdseq_top`

## Requirements
- R1: While rst_n is low and after it is released, pll_pd_o is 0, cpu_n_oe_o is 1 and every clk_out bit follows its clk_in bit.
- R2: A power-down is recognised only when pd_n_i, after a SYNC_STAGES-flop synchronizer, is low on two consecutive rising edges of cpu_n_clk_i. A low pulse that is seen on at most one of those edges leaves all clocks running and pll_pd_o at 0.
- R3: clk_in bit 0 (PCI free-running) is the first output to stop after recognition. It parks low, and the change happens only on one of its own falling edges.
- R4: clk_in bit 1 (buffered 66 MHz) stops only after bit 0 has stopped. It parks low on one of its own falling edges.
- R5: Every bit from 2 to NCLK-1 except CPU_IDX (by default bit 2 PCI, bit 3 USB/DOT, bit 4 REF) stops after bit 1 and holds low. No high pulse on any low-parked output is shorter than the high phase of its input.
- R6: Bit CPU_IDX (by default 5, the true CPU clock) parks high on one of its own rising edges, and cpu_n_oe_o is 0 while it is parked. No low pulse on that output is shortened.
- R7: pll_pd_o rises only after the stop acknowledgment of every domain, including the slow REF domain, has reached the sequencing clock. While pll_pd_o is 1, every low-parked output is 0.
- R8: When pd_n_i goes high, pll_pd_o falls with no clock edge in between.
- R9: After release, every output stays stopped until pll_lock_i has been high for LOCK_CYCLES consecutive cpu_n_clk_i rising edges.
- R10: On restart each output resumes on its own parking edge, so its first pulse has full width. Afterwards all outputs toggle again and cpu_n_oe_o is 1.
- R11: A release that arrives while the stop sequence is still in progress aborts it. pll_pd_o never rises, and the clocks come back through the same lock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| pd_n_i | input | 1 | Asynchronous active-low power-down request |
| pll_lock_i | input | 1 | PLL running and locked indication |
| cpu_n_clk_i | input | 1 | CPU complement clock, sequencing domain |
| clk_in | input | NCLK | Free-running source clocks, one per domain |
| clk_out | output | NCLK | Gated clock outputs |
| cpu_n_o | output | 1 | Level driven on the CPU complement pin |
| cpu_n_oe_o | output | 1 | Drive enable of the CPU complement pin |
| pll_pd_o | output | 1 | Power-down command to PLL and VCO |

## Verification
The sequencer can see two events in the same state: the return of the last stop acknowledgment, which would take it to power-down, and a release of the request, which must win. The bench provokes this by releasing pd_n_i partway through the stop sequence, while some domains are parked and REF is still running. It then judges that pll_pd_o never produces a rising event, that the clocks come back only after the lock wait, and that no pulse is shortened on the way down or back up. A separate single-edge low pulse checks that one sample alone can never start a sequence.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

   typedef enum logic [1:0] {
      SEQ_RUN  = 2'd0,
      SEQ_STOP = 2'd1,
      SEQ_DOWN = 2'd2,
      SEQ_WAKE = 2'd3
   } seq_state_t;

   localparam int DOM_FIRST  = 0;
   localparam int DOM_SECOND = 1;

   function automatic int req_source(input int dom);
      if (dom == DOM_FIRST) return -1;
      else if (dom == DOM_SECOND) return DOM_FIRST;
      else return DOM_SECOND;
   endfunction

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pdseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shift_q;

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) shift_q <= {STAGES{RST_VAL}};
      else        shift_q <= {shift_q[STAGES-2:0], d_i};
   end

   assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/pdseq_gate.sv
module pdseq_gate #(
   parameter bit PARK_HIGH   = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic stop_req_i,
   output logic clk_o,
   output logic stopped_o
);
   logic req_s;
   logic stop_q;

   pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk_i (clk_i),
      .rst_n (rst_n),
      .d_i   (stop_req_i),
      .q_o   (req_s)
   );

   if (PARK_HIGH) begin : g_park_high
      // stop flag changes while the clock is high, output held high
      always_ff @(posedge clk_i or negedge rst_n) begin
         if (!rst_n) stop_q <= 1'b0;
         else        stop_q <= req_s;
      end
      assign clk_o = clk_i | stop_q;
   end else begin : g_park_low
      // stop flag changes while the clock is low, output held low
      always_ff @(negedge clk_i or negedge rst_n) begin
         if (!rst_n) stop_q <= 1'b0;
         else        stop_q <= req_s;
      end
      assign clk_o = clk_i & ~stop_q;
   end

   assign stopped_o = stop_q;
endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
   import pdseq_pkg::*;
#(
   parameter int NCLK        = 6,
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_CYCLES = 16
) (
   input  logic            seq_clk_i,
   input  logic            rst_n,
   input  logic            pd_n_i,
   input  logic            lock_i,
   input  logic [NCLK-1:0] ack_i,
   output logic            stop_req_o,
   output logic            down_o
);
   localparam int CW = $clog2(LOCK_CYCLES + 1);

   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("pdseq_ctrl: LOCK_CYCLES must be at least 1");
   end

   logic            pd_s, pd_prev_q, lock_s;
   logic [NCLK-1:0] ack_s;
   logic            qual_low, all_ack;
   seq_state_t      st_q, st_nxt;
   logic [CW-1:0]   cnt_q;
   logic            stop_q, down_q;

   pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
      .clk_i (seq_clk_i), .rst_n (rst_n), .d_i (pd_n_i), .q_o (pd_s)
   );

   pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
      .clk_i (seq_clk_i), .rst_n (rst_n), .d_i (lock_i), .q_o (lock_s)
   );

   for (genvar k = 0; k < NCLK; k++) begin : g_ack
      pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
         .clk_i (seq_clk_i), .rst_n (rst_n), .d_i (ack_i[k]), .q_o (ack_s[k])
      );
   end

   always_ff @(posedge seq_clk_i or negedge rst_n) begin
      if (!rst_n) pd_prev_q <= 1'b1;
      else        pd_prev_q <= pd_s;
   end

   assign qual_low = ~pd_s & ~pd_prev_q;
   assign all_ack  = &ack_s;

   always_comb begin
      st_nxt = st_q;
      case (st_q)
         SEQ_RUN:  if (qual_low) st_nxt = SEQ_STOP;
         SEQ_STOP: begin
            if (pd_s)         st_nxt = SEQ_WAKE;
            else if (all_ack) st_nxt = SEQ_DOWN;
         end
         SEQ_DOWN: if (pd_s) st_nxt = SEQ_WAKE;
         SEQ_WAKE: begin
            if (qual_low) st_nxt = SEQ_STOP;
            else if (lock_s && (cnt_q == CW'(LOCK_CYCLES - 1))) st_nxt = SEQ_RUN;
         end
         default:  st_nxt = SEQ_RUN;
      endcase
   end

   always_ff @(posedge seq_clk_i or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_RUN;
         stop_q <= 1'b0;
         down_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         st_q   <= st_nxt;
         stop_q <= (st_nxt != SEQ_RUN);
         down_q <= (st_nxt == SEQ_DOWN);
         if ((st_q == SEQ_WAKE) && (st_nxt == SEQ_WAKE) && lock_s) cnt_q <= cnt_q + 1'b1;
         else                                                      cnt_q <= '0;
      end
   end

   assign stop_req_o = stop_q;
   assign down_o     = down_q;
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
   import pdseq_pkg::*;
#(
   parameter int NCLK        = 6,
   parameter int CPU_IDX     = 5,
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_CYCLES = 16
) (
   input  logic            rst_n,
   input  logic            pd_n_i,
   input  logic            pll_lock_i,
   input  logic            cpu_n_clk_i,
   input  logic [NCLK-1:0] clk_in,
   output logic [NCLK-1:0] clk_out,
   output logic            cpu_n_o,
   output logic            cpu_n_oe_o,
   output logic            pll_pd_o
);
   if (NCLK < 3) begin : g_bad_nclk
      $error("pdseq_top: NCLK must be at least 3");
   end
   if ((CPU_IDX < 2) || (CPU_IDX >= NCLK)) begin : g_bad_cpu
      $error("pdseq_top: CPU_IDX must lie in 2..NCLK-1");
   end

   logic            stop_req;
   logic            down;
   logic [NCLK-1:0] dom_req;
   logic [NCLK-1:0] dom_stopped;

   pdseq_ctrl #(
      .NCLK(NCLK), .SYNC_STAGES(SYNC_STAGES), .LOCK_CYCLES(LOCK_CYCLES)
   ) u_ctrl (
      .seq_clk_i  (cpu_n_clk_i),
      .rst_n      (rst_n),
      .pd_n_i     (pd_n_i),
      .lock_i     (pll_lock_i),
      .ack_i      (dom_stopped),
      .stop_req_o (stop_req),
      .down_o     (down)
   );

   for (genvar k = 0; k < NCLK; k++) begin : g_dom
      if (req_source(k) < 0) begin : g_head
         assign dom_req[k] = stop_req;
      end else begin : g_chain
         assign dom_req[k] = dom_stopped[req_source(k)];
      end

      pdseq_gate #(
         .PARK_HIGH   (k == CPU_IDX),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_gate (
         .clk_i      (clk_in[k]),
         .rst_n      (rst_n),
         .stop_req_i (dom_req[k]),
         .clk_o      (clk_out[k]),
         .stopped_o  (dom_stopped[k])
      );
   end

   assign cpu_n_o    = cpu_n_clk_i;
   assign cpu_n_oe_o = ~dom_stopped[CPU_IDX];
   assign pll_pd_o   = down & ~pd_n_i;
endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk #(
   parameter int NCLK        = 6,
   parameter int CPU_IDX     = 5,
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_CYCLES = 16
) (
   input logic            seq_clk,
   input logic            rst_n,
   input logic            pd_n_i,
   input logic            pll_lock_i,
   input logic [NCLK-1:0] clk_out,
   input logic            cpu_n_oe_o,
   input logic            pll_pd_o,
   input logic            stop_req
);
   localparam logic [NCLK-1:0] PARK_MASK = NCLK'(1) << CPU_IDX;
   localparam int LW = $clog2(LOCK_CYCLES + 1);

   logic [LW-1:0] lock_run_q;

   always_ff @(posedge seq_clk or negedge rst_n) begin
      if (!rst_n)                               lock_run_q <= '0;
      else if (!pll_lock_i)                     lock_run_q <= '0;
      else if (lock_run_q != LW'(LOCK_CYCLES))  lock_run_q <= lock_run_q + 1'b1;
   end

   // R7
   all_low_parked_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
      pll_pd_o |-> ((clk_out & ~PARK_MASK) == '0));

   // R6
   cpu_parked_high_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
      pll_pd_o |-> (clk_out[CPU_IDX] && !cpu_n_oe_o));

   // R2
   two_sample_qual_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
      $rose(stop_req) |-> (!$past(pd_n_i, SYNC_STAGES + 1) && !$past(pd_n_i, SYNC_STAGES + 2)));

   // R9
   lock_wait_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
      $fell(stop_req) |-> (lock_run_q >= LW'(LOCK_CYCLES)));
endmodule

bind pdseq_top pdseq_chk #(
   .NCLK(NCLK), .CPU_IDX(CPU_IDX), .SYNC_STAGES(SYNC_STAGES), .LOCK_CYCLES(LOCK_CYCLES)
) u_pdseq_chk (
   .seq_clk    (cpu_n_clk_i),
   .rst_n      (rst_n),
   .pd_n_i     (pd_n_i),
   .pll_lock_i (pll_lock_i),
   .clk_out    (clk_out),
   .cpu_n_oe_o (cpu_n_oe_o),
   .pll_pd_o   (pll_pd_o),
   .stop_req   (stop_req)
);

// File: tb/test_pdseq_top.sv
`timescale 1ns/100ps
module test_pdseq_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCLK       = 6;
   localparam int CPU_IDX    = 5;
   localparam int LOCK       = 16;
   localparam int HALF [NCLK] = '{15, 8, 17, 11, 70, CLK_PERIOD / 2};
   localparam int PLL_EV     = 99;

   logic            rst_n, pd_n, lock, cpu_n_clk;
   logic            c_pcif, c_b66, c_pci, c_usb, c_ref;
   logic [NCLK-1:0] clk_in, clk_out;
   logic            cpu_n_o, cpu_n_oe, pll_pd;

   assign clk_in = {~cpu_n_clk, c_ref, c_usb, c_pci, c_b66, c_pcif};

   pdseq_top #(.NCLK(NCLK), .CPU_IDX(CPU_IDX), .SYNC_STAGES(2), .LOCK_CYCLES(LOCK)) i_pdseq_top (
      .rst_n(rst_n), .pd_n_i(pd_n), .pll_lock_i(lock), .cpu_n_clk_i(cpu_n_clk),
      .clk_in(clk_in), .clk_out(clk_out), .cpu_n_o(cpu_n_o), .cpu_n_oe_o(cpu_n_oe),
      .pll_pd_o(pll_pd)
   );

   initial begin cpu_n_clk = 0; forever #(CLK_PERIOD / 2) cpu_n_clk = ~cpu_n_clk; end
   initial begin c_pcif = 0; forever #(HALF[0]) c_pcif = ~c_pcif; end
   initial begin c_b66  = 0; forever #(HALF[1]) c_b66  = ~c_b66;  end
   initial begin c_pci  = 0; #3; forever #(HALF[2]) c_pci = ~c_pci; end
   initial begin c_usb  = 0; #1; forever #(HALF[3]) c_usb = ~c_usb; end
   initial begin c_ref  = 0; forever #(HALF[4]) c_ref  = ~c_ref;  end

   int  n_cmp = 0, n_bad = 0;
   int  exp_q[$];
   int  rise_cnt[NCLK];
   int  run_len[NCLK];
   bit  in_run[NCLK], prev_act[NCLK], stop_seen[NCLK];
   bit  primed = 0, prev_pll = 0, track_order = 0, done = 0;
   int  pll_rises = 0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // driver side of the scoreboard
   task automatic push_exp(int id);
      exp_q.push_back(id);
   endtask

   task automatic observe(int id);
      string req;
      req = (id == 0) ? "R3" : (id == 1) ? "R4" : "R7";
      if (exp_q.size() == 0) check(1'b0, req, "unexpected stop event", id, -1);
      else begin
         int e;
         e = exp_q.pop_front();
         check(e == id, req, "stop event order", id, e);
      end
   endtask

   // monitor: samples half-way between 1 ns grid points
   initial begin
      #0.5;
      forever begin
         if (rst_n) begin
            for (int k = 0; k < NCLK; k++) begin
               bit park, i, o, act, parked, running;
               park    = (k == CPU_IDX);
               i       = clk_in[k];
               o       = clk_out[k];
               act     = park ? ~o : o;
               parked  = park ? (!i && o) : (i && !o);
               running = park ? (!i && !o) : (i && o);
               if (primed) begin
                  if (act && !prev_act[k]) begin
                     rise_cnt[k]++;
                     in_run[k]  = 1;
                     run_len[k] = 1;
                  end else if (act && in_run[k]) begin
                     run_len[k]++;
                  end else if (!act && prev_act[k] && in_run[k]) begin
                     // R5 / R6 / R10: no shortened pulse
                     check(run_len[k] == HALF[k], park ? "R6" : "R5",
                           $sformatf("pulse width dom %0d", k), run_len[k], HALF[k]);
                     in_run[k] = 0;
                  end
                  if (parked && !stop_seen[k]) begin
                     stop_seen[k] = 1;
                     if (track_order && k < 2) observe(k);
                  end else if (running) begin
                     stop_seen[k] = 0;
                  end
               end
               prev_act[k] = act;
            end
            if (primed && pll_pd && !prev_pll) begin
               pll_rises++;
               observe(PLL_EV);
               check((clk_out & ~(NCLK'(1) << CPU_IDX)) == '0, "R7", "outputs low at pll_pd rise",
                     int'(clk_out), 0);
            end
            prev_pll = pll_pd;
            primed   = 1;
         end
         #1;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #100000;
      check(1'b0, "R1", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int snap[NCLK];
      rst_n = 0; pd_n = 1; lock = 1;
      #2;
      #50;
      check(pll_pd == 0 && cpu_n_oe == 1, "R1", "outputs during reset", int'({pll_pd, cpu_n_oe}), 1);
      rst_n = 1;
      #200;
      check(pll_pd == 0 && cpu_n_oe == 1, "R1", "outputs after reset", int'({pll_pd, cpu_n_oe}), 1);
      check(rise_cnt[0] > 0 && rise_cnt[4] > 0, "R1", "clocks pass after reset", rise_cnt[4], 1);

      // single-sample low pulse must be ignored
      track_order = 1;
      for (int k = 0; k < NCLK; k++) snap[k] = rise_cnt[k];
      pd_n = 0; #5; pd_n = 1; #5;
      #400;
      check(pll_pd == 0, "R2", "pll_pd after short pulse", pll_pd, 0);
      check(rise_cnt[0] > snap[0] + 5, "R2", "pcif still toggling", rise_cnt[0] - snap[0], 6);
      check(stop_seen[0] == 0 && stop_seen[1] == 0, "R2", "no stop after short pulse",
            int'({stop_seen[1], stop_seen[0]}), 0);

      // full power-down
      push_exp(0); push_exp(1); push_exp(PLL_EV);
      pd_n = 0; lock = 0;
      for (int w = 0; w < 2000; w++) begin
         if (pll_pd) break;
         #10;
      end
      check(pll_pd == 1, "R7", "pll_pd reached", pll_pd, 1);
      for (int k = 0; k < NCLK; k++) snap[k] = rise_cnt[k];
      #500;
      for (int k = 0; k < NCLK; k++)
         if (k != CPU_IDX)
            check(rise_cnt[k] == snap[k], "R5", $sformatf("dom %0d held low", k), rise_cnt[k] - snap[k], 0);
      check(clk_out[CPU_IDX] == 1 && cpu_n_oe == 0, "R6", "cpu parked high, cpu_n floated",
            int'({clk_out[CPU_IDX], cpu_n_oe}), 2);
      check(exp_q.size() == 0, "R4", "all ordered events seen", exp_q.size(), 0);

      // release: immediate pll power-up, clocks wait for lock
      pd_n = 1;
      #1;
      check(pll_pd == 0, "R8", "pll_pd falls at once", pll_pd, 0);
      #9;
      #500;
      check(rise_cnt[0] == snap[0] && rise_cnt[4] == snap[4], "R9", "clocks wait while unlocked",
            rise_cnt[0] - snap[0], 0);
      check(cpu_n_oe == 0, "R9", "cpu_n stays floated while unlocked", cpu_n_oe, 0);
      lock = 1;
      #1500;
      for (int k = 0; k < NCLK; k++)
         check(rise_cnt[k] > snap[k], "R10", $sformatf("dom %0d restarted", k), rise_cnt[k] - snap[k], 1);
      check(cpu_n_oe == 1, "R10", "cpu_n driven again", cpu_n_oe, 1);

      // release arriving mid-sequence aborts power-down
      track_order = 0;
      begin
         int base_pll;
         base_pll = pll_rises;
         pd_n = 0;
         #120;
         pd_n = 1;
         #1500;
         check(pll_rises == base_pll, "R11", "no pll_pd after abort", pll_rises - base_pll, 0);
         for (int k = 0; k < NCLK; k++) snap[k] = rise_cnt[k];
         #400;
         check(rise_cnt[0] > snap[0] && rise_cnt[4] > snap[4], "R11", "clocks running after abort",
               rise_cnt[4] - snap[4], 1);
         check(cpu_n_oe == 1, "R11", "cpu_n driven after abort", cpu_n_oe, 1);
      end
      finish_run();
   end
endmodule